// File: doc/BRIEF.md
# Target Row Refresh Mitigation Engine

This block sits beside a single DRAM bank and watches the command stream that reaches it. Every cycle carries one command: idle, row activation (with a row address), precharge, or refresh. Activations of rows that pass an address-dependent admission test are tracked in a small sampler. Each tracked row has an activation counter, a flag for which neighbour to serve next, and an age rank. When the sampler is full, a newly admitted row displaces the weakest tracked row.

On each refresh command the engine picks the tracked row with the most activations. It emits a one-cycle victim-refresh strobe carrying the address of one physically adjacent row, then clears that row's counter. At most one victim is served per refresh. A flood of aggressor rows can therefore overflow the sampler, and this is the weakness the block is meant to model. A refresh counter tracks position inside the retention window and pulses when the window wraps.

Top module: `trr_engine`

## Requirements
- R1: After reset the strobe `vref_valid` is low, `ref_count` is 0, `window_wrap` is low and the sampler is empty.
- R2: A refresh (`cmd_op` = 3) that arrives while the sampler is empty produces no strobe.
- R3: A refresh that arrives while the sampler holds at least one row produces exactly one strobe, in the cycle after the command. The strobe is never high in any other cycle.
- R4: An activation (`cmd_op` = 1) is admitted only when the parity of `cmd_row & ADMIT_MASK` equals `ADMIT_PARITY` (defaults 'h3 and 0, so rows whose two low bits are 00 or 11 are admitted). An activation that is not admitted changes nothing.
- R5: An admitted activation of a row already tracked raises its count by one, saturating at 2^CNT_W-1. An untracked row enters with count 1. Several rows can be captured between two refreshes.
- R6: At most ENTRIES rows are tracked. When the sampler is full, a new admitted row replaces the tracked row with the lowest count, and among equal counts the one admitted earliest.
- R7: The row served by a refresh is the tracked row with the highest count, and among equal counts the one admitted earliest.
- R8: The strobe address is the served row plus one or minus one. A newly tracked row is first served upward. Each service clears that row's count and flips its direction for the next service.
- R9: At the array edges the missing neighbour is replaced by the existing one. Row 0 is always served as row 1, and row 2^ROW_W-1 as row 2^ROW_W-2.
- R10: Idle (`cmd_op` = 0) and precharge (`cmd_op` = 2) commands change neither the sampler nor the outputs.
- R11: `ref_count` advances by one per refresh and returns to 0 after REFS_PER_WINDOW refreshes. `window_wrap` pulses for one cycle with the refresh that returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command: 0 idle, 1 activate, 2 precharge, 3 refresh |
| cmd_row | input | ROW_W | Row address, used with activate |
| vref_valid | output | 1 | Victim-refresh strobe |
| vref_row | output | ROW_W | Victim row address, valid with the strobe |
| ref_count | output | clog2(REFS_PER_WINDOW) | Refreshes seen in the current retention window |
| window_wrap | output | 1 | One-cycle pulse when the window count wraps |

## Verification
A wrong count, age rank or direction flag in the sampler stays hidden until the next refresh. It then appears as a strobe on the wrong neighbour or the wrong row, one cycle after that refresh. A wrong eviction choice surfaces later still: it appears when the displaced row would have been the highest-count source, or when it fails to take a count. The reference model therefore compares every output on every cycle. It drives long refresh sequences after each activation pattern, so that every tracked row is drained out through the strobe.

// File: rtl/trr_pkg.sv
package trr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ACT  = 2'd1,
    OP_PRE  = 2'd2,
    OP_REF  = 2'd3
  } trr_op_e;

endpackage

// File: rtl/trr_sampler.sv
module trr_sampler #(
  parameter int ROW_W   = 10,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              act_en,
  input  logic [ROW_W-1:0]                  act_row,
  input  logic                              svc_en,
  input  logic [IDX_W-1:0]                  svc_idx,
  output logic [ENTRIES-1:0]                ent_valid,
  output logic [ENTRIES-1:0][ROW_W-1:0]     ent_row,
  output logic [ENTRIES-1:0][CNT_W-1:0]     ent_cnt,
  output logic [ENTRIES-1:0][IDX_W-1:0]     ent_age,
  output logic [ENTRIES-1:0]                ent_side,
  output logic                              hit_any,
  output logic                              alloc_free,
  output logic                              evict_en
);

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][ROW_W-1:0] row_q;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [ENTRIES-1:0]            side_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   evict_idx;
  logic [IDX_W-1:0]   ins_idx;
  logic [ENTRIES-1:0] bump;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  // a is a weaker eviction candidate than b: fewer activations, or older on a tie
  function automatic logic weaker(input logic [CNT_W-1:0] a_cnt, input logic [IDX_W-1:0] a_age,
                                  input logic [CNT_W-1:0] b_cnt, input logic [IDX_W-1:0] b_age);
    return (a_cnt < b_cnt) || ((a_cnt == b_cnt) && (a_age > b_age));
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = valid_q[g] && (row_q[g] == act_row);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    evict_idx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (weaker(cnt_q[i], age_q[i], cnt_q[evict_idx], age_q[evict_idx])) evict_idx = IDX_W'(i);
    end
  end

  assign hit_any    = |hit_vec;
  assign ins_idx    = free_any ? free_idx : evict_idx;
  assign alloc_free = act_en && !hit_any && free_any;
  assign evict_en   = act_en && !hit_any && !free_any;

  // Age ranks stay unique among valid entries: the newcomer takes rank 0 and
  // every entry younger than the slot it fills moves one rank older.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_bump
    assign bump[g] = valid_q[g] && (IDX_W'(g) != ins_idx) &&
                     (free_any || (age_q[g] < age_q[evict_idx]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      row_q   <= '0;
      cnt_q   <= '0;
      age_q   <= '0;
      side_q  <= '0;
    end else begin
      if (act_en) begin
        if (hit_any) begin
          cnt_q[hit_idx] <= sat_inc(cnt_q[hit_idx]);
        end else begin
          for (int i = 0; i < ENTRIES; i++) begin
            if (bump[i]) age_q[i] <= age_q[i] + 1'b1;
          end
          valid_q[ins_idx] <= 1'b1;
          row_q[ins_idx]   <= act_row;
          cnt_q[ins_idx]   <= CNT_W'(1);
          age_q[ins_idx]   <= '0;
          side_q[ins_idx]  <= 1'b0;
        end
      end
      if (svc_en) begin
        cnt_q[svc_idx]  <= '0;
        side_q[svc_idx] <= ~side_q[svc_idx];
      end
    end
  end

  assign ent_valid = valid_q;
  assign ent_row   = row_q;
  assign ent_cnt   = cnt_q;
  assign ent_age   = age_q;
  assign ent_side  = side_q;

endmodule

// File: rtl/trr_picker.sv
module trr_picker #(
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
  input  logic [ENTRIES-1:0][IDX_W-1:0] ent_age,
  output logic                          pick_any,
  output logic [IDX_W-1:0]              pick_idx
);

  // a beats b as refresh source: more activations, or older on a tie
  function automatic logic stronger(input logic [CNT_W-1:0] a_cnt, input logic [IDX_W-1:0] a_age,
                                    input logic [CNT_W-1:0] b_cnt, input logic [IDX_W-1:0] b_age);
    return (a_cnt > b_cnt) || ((a_cnt == b_cnt) && (a_age > b_age));
  endfunction

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_valid[i] &&
          (!pick_any || stronger(ent_cnt[i], ent_age[i], ent_cnt[pick_idx], ent_age[pick_idx]))) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trr_victim.sv
module trr_victim #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ROW_W-1:0] src_row,
  input  logic             src_side,
  output logic             vref_valid,
  output logic [ROW_W-1:0] vref_row
);

  localparam logic [ROW_W-1:0] ROW_TOP = '1;

  // side 0 asks for the upper neighbour, side 1 for the lower; a missing
  // neighbour at an array edge is replaced by the one that exists
  function automatic logic [ROW_W-1:0] neighbour(input logic [ROW_W-1:0] r, input logic side);
    logic go_up;
    go_up = !side;
    if (go_up && (r == ROW_TOP)) go_up = 1'b0;
    else if (!go_up && (r == '0)) go_up = 1'b1;
    return go_up ? r + 1'b1 : r - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_valid <= 1'b0;
      vref_row   <= '0;
    end else begin
      vref_valid <= fire;
      if (fire) vref_row <= neighbour(src_row, src_side);
    end
  end

endmodule

// File: rtl/trr_refcnt.sv
module trr_refcnt #(
  parameter int REFS_PER_WINDOW = 8192,
  localparam int RC_W = $clog2(REFS_PER_WINDOW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [RC_W-1:0] count,
  output logic            wrap
);

  localparam logic [RC_W-1:0] LAST = RC_W'(REFS_PER_WINDOW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (tick) begin
        if (count == LAST) begin
          count <= '0;
          wrap  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trr_engine.sv
module trr_engine
  import trr_pkg::*;
#(
  parameter int               ROW_W           = 10,
  parameter int               ENTRIES         = 4,
  parameter int               CNT_W           = 6,
  parameter logic [ROW_W-1:0] ADMIT_MASK      = 'h3,
  parameter logic             ADMIT_PARITY    = 1'b0,
  parameter int               REFS_PER_WINDOW = 8192,
  localparam int              RC_W            = $clog2(REFS_PER_WINDOW),
  localparam int              IDX_W           = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             vref_valid,
  output logic [ROW_W-1:0] vref_row,
  output logic [RC_W-1:0]  ref_count,
  output logic             window_wrap
);

  function automatic logic admissible(input logic [ROW_W-1:0] r);
    return (^(r & ADMIT_MASK)) == ADMIT_PARITY;
  endfunction

  trr_op_e op;
  logic    is_act, is_ref, act_admit, act_en, svc_en;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][ROW_W-1:0] ent_row;
  logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;
  logic [ENTRIES-1:0][IDX_W-1:0] ent_age;
  logic [ENTRIES-1:0]            ent_side;
  logic                          hit_any, alloc_free, evict_en;
  logic                          pick_any;
  logic [IDX_W-1:0]              pick_idx;
  logic [ROW_W-1:0]              src_row;
  logic                          src_side;

  assign op        = trr_op_e'(cmd_op);
  assign is_act    = (op == OP_ACT);
  assign is_ref    = (op == OP_REF);
  assign act_admit = admissible(cmd_row);
  assign act_en    = is_act && act_admit;
  assign svc_en    = is_ref && pick_any;
  assign src_row   = ent_row[pick_idx];
  assign src_side  = ent_side[pick_idx];

  trr_sampler #(.ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_en), .act_row(cmd_row),
    .svc_en(svc_en), .svc_idx(pick_idx),
    .ent_valid(ent_valid), .ent_row(ent_row), .ent_cnt(ent_cnt),
    .ent_age(ent_age), .ent_side(ent_side),
    .hit_any(hit_any), .alloc_free(alloc_free), .evict_en(evict_en)
  );

  trr_picker #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_picker (
    .ent_valid(ent_valid), .ent_cnt(ent_cnt), .ent_age(ent_age),
    .pick_any(pick_any), .pick_idx(pick_idx)
  );

  trr_victim #(.ROW_W(ROW_W)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .fire(svc_en), .src_row(src_row), .src_side(src_side),
    .vref_valid(vref_valid), .vref_row(vref_row)
  );

  trr_refcnt #(.REFS_PER_WINDOW(REFS_PER_WINDOW)) u_refcnt (
    .clk(clk), .rst_n(rst_n), .tick(is_ref),
    .count(ref_count), .wrap(window_wrap)
  );

endmodule

// File: rtl/trr_engine_chk.sv
module trr_engine_chk #(
  parameter int ROW_W   = 10,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 6,
  parameter int RC_W    = 13,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          is_act,
  input logic                          is_ref,
  input logic                          act_admit,
  input logic                          pick_any,
  input logic [IDX_W-1:0]              pick_idx,
  input logic [ENTRIES-1:0]            ent_valid,
  input logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt,
  input logic [ROW_W-1:0]              src_row,
  input logic                          vref_valid,
  input logic [ROW_W-1:0]              vref_row,
  input logic [RC_W-1:0]               ref_count,
  input logic                          window_wrap
);

  logic higher_seen;
  always_comb begin
    higher_seen = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_valid[i] && (ent_cnt[i] > ent_cnt[pick_idx])) higher_seen = 1'b1;
    end
  end

  assert_no_stray_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vref_valid |-> $past(is_ref));

  assert_one_strobe_per_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && pick_any) |=> vref_valid);

  assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && (ent_valid == '0)) |=> !vref_valid);

  assert_victim_adjacent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && pick_any) |=> ((vref_row == ROW_W'($past(src_row) + 1'b1)) ||
                              (vref_row == ROW_W'($past(src_row) - 1'b1))));

  assert_rejected_row_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && !act_admit) |=> ($stable(ent_valid) && $stable(ent_cnt)));

  assert_pick_highest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> !higher_seen);

  assert_refcount_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> ((ref_count == RC_W'($past(ref_count) + 1'b1)) || ((ref_count == '0) && window_wrap)));

  assert_wrap_on_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    window_wrap |-> ($past(is_ref) && (ref_count == '0)));

endmodule

bind trr_engine trr_engine_chk #(
  .ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .RC_W(RC_W)
) u_trr_engine_chk (
  .clk(clk), .rst_n(rst_n), .is_act(is_act), .is_ref(is_ref), .act_admit(act_admit),
  .pick_any(pick_any), .pick_idx(pick_idx), .ent_valid(ent_valid), .ent_cnt(ent_cnt),
  .src_row(src_row), .vref_valid(vref_valid), .vref_row(vref_row),
  .ref_count(ref_count), .window_wrap(window_wrap)
);

// File: tb/test_trr_engine.sv
module test_trr_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 10;
  localparam int ENTRIES    = 4;
  localparam int CNT_W      = 6;
  localparam int MASK       = 'h3;
  localparam int PARITY     = 0;
  localparam int REFS       = 8192;
  localparam int RC_W       = $clog2(REFS);
  localparam int ROW_TOP    = (1 << ROW_W) - 1;
  localparam int CNT_TOP    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic             vref_valid;
  logic [ROW_W-1:0] vref_row;
  logic [RC_W-1:0]  ref_count;
  logic             window_wrap;

  trr_engine #(.ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .ADMIT_MASK(ROW_W'(MASK)),
               .ADMIT_PARITY(1'(PARITY)), .REFS_PER_WINDOW(REFS)) i_trr_engine (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .vref_valid(vref_valid), .vref_row(vref_row), .ref_count(ref_count), .window_wrap(window_wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // reference model: tracked rows kept in admission order, oldest at the front
  int m_row[$];
  int m_cnt[$];
  int m_side[$];
  bit exp_v;
  int exp_row;
  int exp_rc;
  bit exp_wrap;

  function automatic bit admitted(int r);
    return ($countones(r & MASK) % 2) == PARITY;
  endfunction

  function automatic void model_step(int op, int r);
    exp_v = 0;
    exp_wrap = 0;
    if (op == 1 && admitted(r)) begin
      int at = -1;
      foreach (m_row[k]) if (m_row[k] == r) at = k;
      if (at >= 0) begin
        if (m_cnt[at] < CNT_TOP) m_cnt[at]++;
      end else begin
        if (m_row.size() == ENTRIES) begin
          int lo = 0;
          foreach (m_cnt[k]) if (m_cnt[k] < m_cnt[lo]) lo = k;
          m_row.delete(lo); m_cnt.delete(lo); m_side.delete(lo);
        end
        m_row.push_back(r); m_cnt.push_back(1); m_side.push_back(0);
      end
    end else if (op == 3) begin
      if (exp_rc == REFS - 1) begin exp_rc = 0; exp_wrap = 1; end
      else exp_rc++;
      if (m_row.size() > 0) begin
        int hi = 0;
        int rw;
        bit up;
        foreach (m_cnt[k]) if (m_cnt[k] > m_cnt[hi]) hi = k;
        rw = m_row[hi];
        up = (m_side[hi] == 0);
        if (up && rw == ROW_TOP) up = 0;
        else if (!up && rw == 0) up = 1;
        exp_row = up ? rw + 1 : rw - 1;
        exp_v = 1;
        m_cnt[hi] = 0;
        m_side[hi] = 1 - m_side[hi];
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_row.delete(); m_cnt.delete(); m_side.delete();
      exp_v = 0; exp_row = 0; exp_rc = 0; exp_wrap = 0;
    end else begin
      model_step(int'(cmd_op), int'(cmd_row));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (vref_valid !== exp_v || (exp_v && vref_row !== ROW_W'(exp_row)) ||
          ref_count !== RC_W'(exp_rc) || window_wrap !== exp_wrap) begin
        n_fails++;
        $display("FAIL %s t=%0t: got strobe=%0b row=%0d count=%0d wrap=%0b, expected strobe=%0b row=%0d count=%0d wrap=%0b",
                 cur_req, $time, vref_valid, vref_row, ref_count, window_wrap,
                 exp_v, exp_row, exp_rc, exp_wrap);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int want);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic cmd(input int op, input int r);
    @(negedge clk);
    cmd_op  = 2'(op);
    cmd_row = ROW_W'(r);
  endtask

  task automatic act(input int r, input int times);
    for (int k = 0; k < times; k++) cmd(1, r);
  endtask

  task automatic refs(input int times);
    for (int k = 0; k < times; k++) begin
      cmd(3, 0);
      cmd(0, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_op = 2'd0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_test();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got no end, expected end before 200000 cycles");
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(vref_valid === 1'b0, "R1 strobe", int'(vref_valid), 0);
    check(ref_count === '0, "R1 ref_count", int'(ref_count), 0);
    check(window_wrap === 1'b0, "R1 wrap", int'(window_wrap), 0);

    // R2: refresh on empty sampler
    cur_req = "R2";
    refs(2);

    // R4: rows 1 and 2 are not admitted (low bits 01, 10), sampler stays empty
    cur_req = "R4";
    act(1, 3); act(2, 2); act(6, 1);
    refs(2);

    // R10: idle and precharge leave everything alone
    cur_req = "R10";
    act(4, 2);
    cmd(2, 4); cmd(2, 8); cmd(0, 0); cmd(2, 0);
    refs(2);

    // R5 / R7 / R8: several rows captured between refreshes, served by count
    cur_req = "R5";
    do_reset();
    act(4, 3); act(8, 1); act(12, 2);
    cur_req = "R7";
    refs(5);
    cur_req = "R8";
    act(12, 1);
    refs(4);

    // R5 saturation of the count
    cur_req = "R5";
    act(16, 70); act(19, 65);
    refs(3);

    // R9: array edges
    cur_req = "R9";
    do_reset();
    act(0, 1);
    refs(3);
    act(ROW_TOP, 2);
    refs(4);

    // R6: eviction of the weakest, oldest on a tie
    cur_req = "R6";
    do_reset();
    act(0, 2); act(3, 1); act(4, 1); act(7, 3);
    act(8, 1);
    act(11, 1);
    act(12, 2);
    refs(6);

    // R3: mixed pseudo-random stream, strobe only after refreshes
    cur_req = "R3";
    do_reset();
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
        int r;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        r = (lf[7]) ? int'(lf[15:8]) % 24 : ((lf[6]) ? ROW_TOP : int'(lf[15:10]));
        cmd(int'(lf[1:0]), r);
      end
    end

    // R11: refresh window wraps
    cur_req = "R11";
    do_reset();
    act(20, 1);
    for (int k = 0; k < REFS + 3; k++) cmd(3, 0);
    cmd(0, 0);
    repeat (3) @(negedge clk);
    finish_test();
  end

endmodule